// File: doc/BRIEF.md
# Three-Wire Serial Memory Read Slave

This block is the device side of a three-wire serial memory: a select line, a serial clock and a serial data input, plus a serial data output with its own output-enable so the pad can be tri-stated. Inside sits a 512-word by 16-bit array. Every word comes up holding FFFFh, or another word chosen by a parameter. A backdoor write port lets a testbench load any image through the serial clock domain.

Once select goes high, the block waits through any number of low "dummy" clocks for a leading one. That one is the start bit. The block then takes a two-bit command, a don't-care bit and a nine-bit word address. If the command is a read, the output turns on with a single zero marker bit. The addressed word follows, most significant bit first. While clocking continues, the words that follow stream out with no further marker, and the address wraps from the last word back to word 0. Any other command is absorbed silently until select drops. Dropping select ends the frame at once and turns the output off.

Top module: `sm3_slave`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `sclk` edge) sets every array word to `INIT_WORD` (default 16'hFFFF) and leaves `sdo_oe` low.
- R2: While `sel` is high and no start bit has been seen yet, rising edges that sample `sdi` low are discarded, and `sdo_oe` stays low throughout.
- R3: The frame, sampled on rising `sclk` edges, is: start bit (1), a two-bit command sent first bit first, where 2'b10 means read, one don't-care bit, then a nine-bit address sent bit 8 first down to bit 0.
- R4: `sdo_oe` stays low up to and including the edge before the one that samples address bit 0. From that edge on, the block drives `sdo` = 0 (the marker bit).
- R5: On each of the following 16 rising edges, one bit of the addressed word appears on `sdo`, bit 15 first and bit 0 last.
- R6: If clocking continues with `sel` high after bit 0, the next rising edge presents bit 15 of the word at address+1, with no marker bit in between.
- R7: The address that follows word 511 is word 0.
- R8: When `sel` goes low, `sdo_oe` drops without waiting for a clock edge. The frame state is cleared, so the next high phase of `sel` starts a new frame that needs its own start bit.
- R9: If the command is not 2'b10, `sdo_oe` stays low for the rest of the frame, whatever `sdi` carries, until `sel` falls.
- R10: When `bd_we` is high at a rising `sclk` edge, `bd_data` is stored at `bd_addr`, and a later read of that address returns it.
- R11: While `sel` is low, `sclk` and `sdi` have no effect on the frame: ones clocked in during that time are not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all sampling is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select, active high; low means standby |
| sdi | input | 1 | Serial data in |
| bd_we | input | 1 | Backdoor write strobe |
| bd_addr | input | 9 | Backdoor write address |
| bd_data | input | 16 | Backdoor write data |
| sdo | output | 1 | Serial data out (forced 0 while disabled) |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |

## Verification
The marker bit is due in the same edge that samples address bit 0, the thirteenth edge counted from the start bit. Each data bit is due one edge after the previous one, so the first word's bit 0 appears sixteen edges after the marker, and the next word's bit 15 one edge after that. The bench changes `sdi` on the falling edge and reads `sdo` and `sdo_oe` on the next falling edge, after exactly one rising edge has acted. The one exception is the response to deselect, which is combinational and is read one time step after `sel` falls, with no clock edge in between.

// File: rtl/sm3_pkg.sv
package sm3_pkg;

    // Default geometry of the array and the frame layout.
    localparam int ADDR_W   = 9;
    localparam int DATA_W   = 16;
    localparam int CMD_W    = 2;
    localparam int PAD_W    = 1;
    localparam logic [CMD_W-1:0] CMD_READ = 2'b10;
    localparam logic [DATA_W-1:0] BLANK_WORD = 16'hFFFF;

    // Frame phases of the command decoder.
    typedef enum logic [2:0] {
        PH_IDLE,   // waiting for the leading one
        PH_CMD,    // shifting in the command bits
        PH_PAD,    // don't-care bit(s)
        PH_ADR,    // shifting in the address, MSB first
        PH_DATA,   // streaming words out
        PH_SINK    // unsupported command: absorb until deselect
    } phase_e;

    // Strobes from the decoder to the serializer.
    typedef struct packed {
        logic first;    // address complete: emit marker, load word
        logic advance;  // last bit of a word going out: load next word
    } load_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sm3_array.sv
module sm3_array
    import sm3_pkg::*;
#(
    parameter int ADDR_W = sm3_pkg::ADDR_W,
    parameter int DATA_W = sm3_pkg::DATA_W,
    parameter logic [DATA_W-1:0] INIT_WORD = sm3_pkg::BLANK_WORD
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              bd_we,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [DATA_W-1:0] bd_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge sclk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= INIT_WORD;
            end
        end else if (bd_we) begin
            mem_q[bd_addr] <= bd_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/sm3_frame_dec.sv
module sm3_frame_dec
    import sm3_pkg::*;
#(
    parameter int ADDR_W = sm3_pkg::ADDR_W,
    parameter int DATA_W = sm3_pkg::DATA_W,
    parameter int CMD_W  = sm3_pkg::CMD_W,
    parameter int PAD_W  = sm3_pkg::PAD_W,
    parameter logic [CMD_W-1:0] CMD_READ = sm3_pkg::CMD_READ
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              sel,
    input  logic              sdi,
    output load_t             ld,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam int CNT_W = $clog2(max2(max2(DATA_W, ADDR_W), max2(CMD_W, PAD_W)) + 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAD_W - 1);
    localparam logic [CNT_W-1:0] ADR_LAST  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    phase_e             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CMD_W-1:0]   cmd_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [ADDR_W-1:0]  addr_shift;
    logic [CMD_W-1:0]   cmd_shift;

    assign addr_shift = {addr_q[ADDR_W-2:0], sdi};
    assign cmd_shift  = {cmd_q[CMD_W-2:0], sdi};

    // Read address and load strobes for the edge about to happen.
    always_comb begin
        ld      = '0;
        rd_addr = addr_q;
        case (phase_q)
            PH_ADR: begin
                if (cnt_q == ADR_LAST) begin
                    ld.first = 1'b1;
                    rd_addr  = addr_shift;
                end
            end
            PH_DATA: begin
                if (cnt_q == DATA_LAST) begin
                    ld.advance = 1'b1;
                    rd_addr    = addr_q + 1'b1;   // wraps at the top
                end
            end
            default: ;
        endcase
    end

    // Deselect clears the frame at once; reset clears it on an edge.
    always_ff @(posedge sclk or negedge sel) begin
        if (!sel) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
        end else if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (sdi) begin
                        phase_q <= PH_CMD;
                        cnt_q   <= '0;
                    end
                end
                PH_CMD: begin
                    cmd_q <= cmd_shift;
                    if (cnt_q == CMD_LAST) begin
                        cnt_q   <= '0;
                        phase_q <= (cmd_shift == CMD_READ) ? PH_PAD : PH_SINK;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_PAD: begin
                    if (cnt_q == PAD_LAST) begin
                        cnt_q   <= '0;
                        phase_q <= PH_ADR;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_ADR: begin
                    addr_q <= addr_shift;
                    if (cnt_q == ADR_LAST) begin
                        cnt_q   <= '0;
                        phase_q <= PH_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt_q == DATA_LAST) begin
                        cnt_q  <= '0;
                        addr_q <= rd_addr;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_SINK;   // stay silent until deselect
            endcase
        end
    end

endmodule

// File: rtl/sm3_serializer.sv
module sm3_serializer
    import sm3_pkg::*;
#(
    parameter int DATA_W = sm3_pkg::DATA_W
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              sel,
    input  load_t             ld,
    input  logic [DATA_W-1:0] word,
    output logic              dout_q,
    output logic              oe_q
);

    logic [DATA_W-1:0] shreg_q;

    always_ff @(posedge sclk or negedge sel) begin
        if (!sel) begin
            shreg_q <= '0;
            dout_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else if (rst) begin
            shreg_q <= '0;
            dout_q  <= 1'b0;
            oe_q    <= 1'b0;
        end else if (ld.first) begin
            shreg_q <= word;       // first word waits one edge behind the marker
            dout_q  <= 1'b0;       // marker bit
            oe_q    <= 1'b1;
        end else if (oe_q) begin
            dout_q  <= shreg_q[DATA_W-1];
            shreg_q <= ld.advance ? word : {shreg_q[DATA_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/sm3_slave.sv
module sm3_slave
    import sm3_pkg::*;
#(
    parameter int ADDR_W = sm3_pkg::ADDR_W,
    parameter int DATA_W = sm3_pkg::DATA_W,
    parameter int CMD_W  = sm3_pkg::CMD_W,
    parameter int PAD_W  = sm3_pkg::PAD_W,
    parameter logic [CMD_W-1:0]  CMD_READ  = sm3_pkg::CMD_READ,
    parameter logic [DATA_W-1:0] INIT_WORD = sm3_pkg::BLANK_WORD
) (
    input  logic              sclk,
    input  logic              rst,
    input  logic              sel,
    input  logic              sdi,
    input  logic              bd_we,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [DATA_W-1:0] bd_data,
    output logic              sdo,
    output logic              sdo_oe
);

    load_t             ld;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              dout_q;
    logic              oe_q;

    sm3_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .INIT_WORD(INIT_WORD)
    ) u_array (
        .sclk   (sclk),
        .rst    (rst),
        .bd_we  (bd_we),
        .bd_addr(bd_addr),
        .bd_data(bd_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    sm3_frame_dec #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CMD_W   (CMD_W),
        .PAD_W   (PAD_W),
        .CMD_READ(CMD_READ)
    ) u_dec (
        .sclk   (sclk),
        .rst    (rst),
        .sel    (sel),
        .sdi    (sdi),
        .ld     (ld),
        .rd_addr(rd_addr)
    );

    sm3_serializer #(
        .DATA_W(DATA_W)
    ) u_ser (
        .sclk  (sclk),
        .rst   (rst),
        .sel   (sel),
        .ld    (ld),
        .word  (rd_data),
        .dout_q(dout_q),
        .oe_q  (oe_q)
    );

    // Deselect turns the driver off without waiting for a clock.
    assign sdo_oe = oe_q & sel;
    assign sdo    = dout_q & sdo_oe;

endmodule

// File: rtl/sm3_slave_chk.sv
module sm3_slave_chk #(
    parameter int ADDR_W = 9,
    parameter int CMD_W  = 2,
    parameter int PAD_W  = 1,
    parameter logic [CMD_W-1:0] CMD_READ = 2'b10
) (
    input logic sclk,
    input logic rst,
    input logic sel,
    input logic sdi,
    input logic sdo,
    input logic sdo_oe
);

    // Edges counted from the start bit (start bit = 1) until the driver may turn on.
    localparam int FIRST_DRIVE = 1 + CMD_W + PAD_W + ADDR_W;
    localparam int NW = $clog2(FIRST_DRIVE + 2);
    localparam logic [NW-1:0] N_MAX = {NW{1'b1}};

    logic             started_q;
    logic [NW-1:0]    n_q;
    logic [CMD_W-1:0] cmd_c;

    // Independent frame observer built from the pins.
    always_ff @(posedge sclk or negedge sel) begin
        if (!sel) begin
            started_q <= 1'b0;
            n_q       <= '0;
            cmd_c     <= '0;
        end else if (rst) begin
            started_q <= 1'b0;
            n_q       <= '0;
            cmd_c     <= '0;
        end else if (!started_q) begin
            if (sdi) begin
                started_q <= 1'b1;
                n_q       <= NW'(1);
            end
        end else begin
            if (n_q != N_MAX) n_q <= n_q + 1'b1;
            if (n_q >= NW'(1) && n_q <= NW'(CMD_W)) cmd_c <= {cmd_c[CMD_W-2:0], sdi};
        end
    end

    // R4
    no_early_drive_chk: assert property (@(posedge sclk) disable iff (rst || !sel)
        sdo_oe |-> (started_q && n_q >= NW'(FIRST_DRIVE)));

    // R4
    marker_zero_chk: assert property (@(posedge sclk) disable iff (rst || !sel)
        $rose(sdo_oe) |-> !sdo);

    // R6
    stream_holds_chk: assert property (@(posedge sclk) disable iff (rst || !sel)
        sdo_oe |=> sdo_oe);

    // R9
    sink_silent_chk: assert property (@(posedge sclk) disable iff (rst || !sel)
        (started_q && n_q > NW'(CMD_W) && cmd_c != CMD_READ) |-> !sdo_oe);

    // R2
    idle_quiet_chk: assert property (@(posedge sclk) disable iff (rst || !sel)
        !started_q |-> !sdo_oe);

endmodule

bind sm3_slave sm3_slave_chk #(
    .ADDR_W  (ADDR_W),
    .CMD_W   (CMD_W),
    .PAD_W   (PAD_W),
    .CMD_READ(CMD_READ)
) u_chk (
    .sclk  (sclk),
    .rst   (rst),
    .sel   (sel),
    .sdi   (sdi),
    .sdo   (sdo),
    .sdo_oe(sdo_oe)
);

// File: tb/sm3_slave_tb.sv
module sm3_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;
    localparam int DW = 16;
    localparam int WATCHDOG = 150000;

    logic          sclk = 1'b0;
    logic          rst;
    logic          sel;
    logic          sdi;
    logic          bd_we;
    logic [AW-1:0] bd_addr;
    logic [DW-1:0] bd_data;
    logic          sdo;
    logic          sdo_oe;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    sm3_slave u_dut (
        .sclk   (sclk),
        .rst    (rst),
        .sel    (sel),
        .sdi    (sdi),
        .bd_we  (bd_we),
        .bd_addr(bd_addr),
        .bd_data(bd_data),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    always #(CLK_PERIOD/2) sclk = ~sclk;

    // Image loaded through the backdoor.
    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        logic [DW-1:0] t;
        t = {7'd0, a} * 16'd97;
        return t ^ 16'hC35A;
    endfunction

    // Vector: {command[1:0], address[8:0], expected word}; non-read rows expect silence.
    localparam int NV = 9;
    localparam logic [26:0] VEC [NV] = '{
        {2'b10, 9'h000, pat(9'h000)},
        {2'b10, 9'h001, pat(9'h001)},
        {2'b10, 9'h123, pat(9'h123)},
        {2'b00, 9'h003, 16'h0000},
        {2'b10, 9'h0F0, pat(9'h0F0)},
        {2'b11, 9'h007, 16'h0000},
        {2'b10, 9'h1FF, pat(9'h1FF)},
        {2'b01, 9'h009, 16'h0000},
        {2'b10, 9'h0AA, pat(9'h0AA)}
    };

    always @(posedge sclk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one bit at a falling edge; return after the next rising edge has acted.
    task automatic tick(input logic b);
        sdi = b;
        @(posedge sclk);
        @(negedge sclk);
    endtask

    // Start bit, command, pad, address MSB first. Checks the enable before the last bit.
    task automatic head(input logic [1:0] cmd, input logic [AW-1:0] a);
        sel = 1'b1;
        tick(1'b1);
        tick(cmd[1]);
        tick(cmd[0]);
        tick(1'b0);
        for (int i = AW-1; i >= 0; i--) begin
            if (i == 0) chk("R4 off before A0", {31'd0, sdo_oe}, 32'd0);
            tick(a[i]);
        end
    endtask

    task automatic marker;
        chk("R4 marker enable", {31'd0, sdo_oe}, 32'd1);
        chk("R4 marker value", {31'd0, sdo}, 32'd0);
    endtask

    task automatic get_word(output logic [DW-1:0] w);
        w = '0;
        for (int i = 0; i < DW; i++) begin
            tick(1'b0);
            w = {w[DW-2:0], sdo};
        end
    endtask

    task automatic drop;
        sel = 1'b0;
        sdi = 1'b0;
        #1;
        chk("R8 enable off on deselect", {31'd0, sdo_oe}, 32'd0);
        @(negedge sclk);
    endtask

    task automatic bd_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bd_we   = 1'b1;
        bd_addr = a;
        bd_data = d;
        @(posedge sclk);
        @(negedge sclk);
        bd_we   = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] w;
        logic          seen;
        rst = 1'b1; sel = 1'b0; sdi = 1'b0;
        bd_we = 1'b0; bd_addr = '0; bd_data = '0;
        repeat (3) @(negedge sclk);
        rst = 1'b0;
        @(negedge sclk);

        // R1: reset state
        chk("R1 enable low after reset", {31'd0, sdo_oe}, 32'd0);
        head(2'b10, 9'd5);
        marker();
        get_word(w);
        chk("R1 blank word at 5", {16'd0, w}, 32'hFFFF);
        drop();
        head(2'b10, 9'd511);
        marker();
        get_word(w);
        chk("R1 blank word at 511", {16'd0, w}, 32'hFFFF);
        drop();

        // R10: backdoor image load
        for (int a = 0; a < (1 << AW); a++) bd_write(AW'(a), pat(AW'(a)));

        // R3 R5 R9: vector table
        for (int v = 0; v < NV; v++) begin
            head(VEC[v][26:25], VEC[v][24:16]);
            if (VEC[v][26:25] == 2'b10) begin
                marker();
                get_word(w);
                chk("R3 R5 read word", {16'd0, w}, {16'd0, VEC[v][15:0]});
            end else begin
                seen = sdo_oe;
                for (int i = 0; i < DW + 1; i++) begin
                    tick(1'b1);
                    seen = seen | sdo_oe;
                end
                chk("R9 silent on other command", {31'd0, seen}, 32'd0);
            end
            drop();
        end

        // R6 R7: continuous read across the top of the array
        head(2'b10, 9'd510);
        marker();
        get_word(w);
        chk("R6 word 510", {16'd0, w}, {16'd0, pat(9'd510)});
        get_word(w);
        chk("R6 word 511 without marker", {16'd0, w}, {16'd0, pat(9'd511)});
        get_word(w);
        chk("R7 wrap to word 0", {16'd0, w}, {16'd0, pat(9'd0)});
        drop();

        // R8: deselect mid-word, then a fresh frame
        head(2'b10, 9'd20);
        marker();
        for (int i = 0; i < 8; i++) tick(1'b0);
        drop();
        sel = 1'b1;
        tick(1'b0);
        chk("R8 no output resumes after reselect", {31'd0, sdo_oe}, 32'd0);
        head(2'b10, 9'd21);
        marker();
        get_word(w);
        chk("R8 fresh frame after abort", {16'd0, w}, {16'd0, pat(9'd21)});
        drop();

        // R2: dummy clocks before the start bit
        sel = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            tick(1'b0);
            seen = seen | sdo_oe;
        end
        chk("R2 quiet during dummy clocks", {31'd0, seen}, 32'd0);
        head(2'b10, 9'd77);
        marker();
        get_word(w);
        chk("R2 read after dummy clocks", {16'd0, w}, {16'd0, pat(9'd77)});
        drop();

        // R11: ones clocked while deselected are not a start bit
        for (int i = 0; i < 4; i++) tick(1'b1);
        chk("R11 enable low in standby", {31'd0, sdo_oe}, 32'd0);
        head(2'b10, 9'd33);
        marker();
        get_word(w);
        chk("R11 read unaffected by standby clocks", {16'd0, w}, {16'd0, pat(9'd33)});
        drop();

        // R10: overwrite one word and read it back
        bd_write(9'h100, 16'hBEEF);
        head(2'b10, 9'h100);
        marker();
        get_word(w);
        chk("R10 backdoor overwrite", {16'd0, w}, 32'hBEEF);
        drop();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule